// File: doc/BRIEF.md
# Real-Time Clock Time Registers with Interrupt Flags

This block keeps a 24-hour time of day (seconds, minutes, hours) in packed BCD, holds a matching alarm time, and turns three kinds of event into one active-high interrupt line. The events are the end of each once-per-second update, a match between the new time and the alarm time, and a periodic pulse taken from one of sixteen rate inputs. Software reaches every register through a byte-wide port pair. A write on the index port picks the register, and the data port then reads or writes that register. Read data is registered and appears one cycle after the read strobe.

Each pulse on `sec_tick` opens an update window of `UIP_CYCLES` clock cycles. A status bit shows the window while it is open. When the window closes, the time advances by one second. A halt bit in the second control register freezes the time and also masks the update-ended interrupt enable. The three event flags latch in a flag register whether or not they are enabled. That register is cleared by reading it. Its top bit, and the `irq` pin, are high only while some latched flag has its enable set.

Register indices: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours, 6 control A, 7 control B, 8 flags. Any other index reads as 0x00 and ignores writes.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A write with `bus_sel`=0 loads bits 3:0 of `bus_wdata` into the index. A write with `bus_sel`=1 stores `bus_wdata` into the indexed register. A read with `bus_sel`=1 places the indexed value on `bus_rdata` one cycle later. The time and alarm registers read back exactly what was written.
- R2: When not halted and no update window is open, a `sec_tick` pulse opens a window. Control A bit 7 reads 1 for exactly `UIP_CYCLES` cycles. When the window ends, seconds advance by one in BCD (units in bits 3:0, tens in bits 7:4). Ticks that arrive while a window is open are ignored.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00.
- R4: While control B bit 7 (halt) is set, no window opens and the time does not change. A write to control B with bit 7 set stores bit 4 as 0, whatever value was written.
- R5: A write to control B with bit 7 clear stores all eight bits, including the daylight-saving bit 0, and they read back unchanged.
- R6: Flag bit 5 sets when, at the end of an update, the new seconds, minutes and hours all equal the alarm registers.
- R7: Flag bit 6 sets on each cycle in which `rate_pulse[n]` is high, where n is control A bits 3:0. A value of n = 0 disables periodic events.
- R8: Flag bit 4 sets at the end of every update window.
- R9: Flags latch whatever the enables are. Flag bit 7 and `irq` are 1 exactly when some flag in bits 6:4 is set and the matching control B bit in 6:4 is also set.
- R10: A read of the flag register returns the flags and clears them. An event in the same cycle as that read stays latched for the next read.
- R11: After reset, every register reads 0x00 and `irq` is 0.
- R12: Control A bit 7 is read-only. Bits 6:0 store what is written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used with the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle strobe for each elapsed second |
| rate_pulse | input | 16 | Periodic rate pulse inputs, selected by control A bits 3:0 |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The bench reads control A on every cycle across an update. It counts how long bit 7 is high, so a window that is one cycle too short or too long is caught, and so is time that advances at the wrong moment. It drives the all-nines boundaries (x9, 59, 23:59:59) and random valid times, and checks them against a BCD model in the bench. A broken carry shows up as a non-BCD digit or a missed wrap. The halt tests write control B with bit 4 set and expect it to read back clear, and they check that ticks leave the time unchanged. A periodic event arrives in the same cycle as a flag read, so a design that lets the clear win would lose that event. A design that gates the latching of a flag by its enable would return a wrong flag byte when the flags are read with their enables off.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int RATE_N = 16;
  localparam int RATE_W = $clog2(RATE_N);

  localparam logic [3:0] IDX_SEC     = 4'd0;
  localparam logic [3:0] IDX_MIN     = 4'd1;
  localparam logic [3:0] IDX_HR      = 4'd2;
  localparam logic [3:0] IDX_ALM_SEC = 4'd3;
  localparam logic [3:0] IDX_ALM_MIN = 4'd4;
  localparam logic [3:0] IDX_ALM_HR  = 4'd5;
  localparam logic [3:0] IDX_CTLA    = 4'd6;
  localparam logic [3:0] IDX_CTLB    = 4'd7;
  localparam logic [3:0] IDX_FLAGS   = 4'd8;

  localparam logic [7:0] BCD_MAX_MS = 8'h59;
  localparam logic [7:0] BCD_MAX_HR = 8'h23;

  // Packed-BCD increment with wrap to zero at the given top value.
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top);
    logic [7:0] r;
    if (v == top) begin
      r = 8'h00;
    end else if (v[3:0] == 4'h9) begin
      r = {v[7:4] + 4'h1, 4'h0};
    end else begin
      r = {v[7:4], v[3:0] + 4'h1};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       halt,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hr,
  output logic [7:0] alm_sec,
  output logic [7:0] alm_min,
  output logic [7:0] alm_hr,
  output logic       uip,
  output logic       upd_evt,
  output logic       alm_evt
);

  localparam int CW = $clog2(UIP_CYCLES + 1);
  localparam int N_ALM = 3;

  logic          uip_q, uip_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;
  logic [7:0]    sec_q, sec_d, min_q, min_d, hr_q, hr_d;
  logic [7:0]    sec_adv, min_adv, hr_adv;
  logic          sec_wrap, min_wrap;
  logic          time_en;
  logic [7:0]    alm_q [N_ALM];

  // update window sequencing
  always_comb begin
    uip_d = uip_q;
    cnt_d = cnt_q;
    adv   = 1'b0;
    if (halt) begin
      uip_d = 1'b0;
      cnt_d = '0;
    end else if (uip_q) begin
      if (cnt_q == '0) begin
        uip_d = 1'b0;
        adv   = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (sec_tick) begin
      uip_d = 1'b1;
      cnt_d = CW'(UIP_CYCLES - 1);
    end
  end

  // time advance and host writes
  always_comb begin
    sec_wrap = (sec_q == BCD_MAX_MS);
    min_wrap = (min_q == BCD_MAX_MS);
    sec_adv  = bcd_next(sec_q, BCD_MAX_MS);
    min_adv  = sec_wrap ? bcd_next(min_q, BCD_MAX_MS) : min_q;
    hr_adv   = (sec_wrap && min_wrap) ? bcd_next(hr_q, BCD_MAX_HR) : hr_q;
    sec_d = adv ? sec_adv : sec_q;
    min_d = adv ? min_adv : min_q;
    hr_d  = adv ? hr_adv  : hr_q;
    if (wr_en && wr_idx == IDX_SEC) sec_d = wr_data;
    if (wr_en && wr_idx == IDX_MIN) min_d = wr_data;
    if (wr_en && wr_idx == IDX_HR)  hr_d  = wr_data;
    time_en = adv || (wr_en && (wr_idx == IDX_SEC || wr_idx == IDX_MIN || wr_idx == IDX_HR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      uip_q <= uip_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (time_en) begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end

  // alarm registers, one per time field
  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    logic alm_en;
    assign alm_en = wr_en && (wr_idx == IDX_ALM_SEC + 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_q[g] <= '0;
      end else if (alm_en) begin
        alm_q[g] <= wr_data;
      end
    end
  end

  assign sec     = sec_q;
  assign min     = min_q;
  assign hr      = hr_q;
  assign alm_sec = alm_q[0];
  assign alm_min = alm_q[1];
  assign alm_hr  = alm_q[2];
  assign uip     = uip_q;
  assign upd_evt = adv;
  assign alm_evt = adv && (sec_adv == alm_q[0]) && (min_adv == alm_q[1]) && (hr_adv == alm_q[2]);

  // window length checker
  logic [CW:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_run_q <= '0;
    end else begin
      chk_run_q <= uip_q ? chk_run_q + (CW+1)'(1) : '0;
    end
  end

  assert_uip_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_run_q <= (CW+1)'(UIP_CYCLES));

  assert_uip_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> $past(sec_tick));

  assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip_q && !(wr_en && wr_idx == IDX_SEC)) |=> $stable(sec_q));

  assert_halt_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !uip_q);

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [3:0] idx,
  output logic       data_wr,
  output logic [6:0] ctla,
  output logic [7:0] ctlb
);

  logic [3:0] idx_q, idx_d;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic       idx_en, a_en, b_en;

  always_comb begin
    idx_en = bus_wr && !bus_sel;
    data_wr = bus_wr && bus_sel;
    a_en   = data_wr && idx_q == IDX_CTLA;
    b_en   = data_wr && idx_q == IDX_CTLB;
    idx_d  = bus_wdata[3:0];
    ctla_d = bus_wdata[6:0];
    ctlb_d = bus_wdata;
    // halting forces the update-ended enable low
    if (bus_wdata[7]) ctlb_d[4] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q <= '0;
    end else if (a_en) begin
      ctla_q <= ctla_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlb_q <= '0;
    end else if (b_en) begin
      ctlb_q <= ctlb_d;
    end
  end

  assign idx  = idx_q;
  assign ctla = ctla_q;
  assign ctlb = ctlb_q;

  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_sel) |=> $stable(idx_q));

  assert_ctlb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel && idx_q == IDX_CTLB) |=> $stable(ctlb_q));

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] evt,
  input  logic [2:0] en,
  input  logic       rd_clr,
  output logic [2:0] flags,
  output logic       irqf
);

  logic [2:0] flags_q, flags_d;
  logic       fl_en;

  always_comb begin
    fl_en   = rd_clr || (evt != '0);
    flags_d = (rd_clr ? 3'b000 : flags_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (fl_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
  assign irqf  = |(flags_q & en);

  assert_evt_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> flags_q[2]);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == 3'b000) |=> flags_q == 3'b000);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sec_tick,
  input  logic [RATE_N-1:0] rate_pulse,
  output logic              irq
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [3:0]        idx;
  logic              data_wr;
  logic [6:0]        ctla;
  logic [7:0]        ctlb;
  logic [7:0]        sec, min, hr, alm_sec, alm_min, alm_hr;
  logic              uip, upd_evt, alm_evt, per_evt;
  logic [2:0]        flags;
  logic              irqf, rd_en, rd_clr;
  logic [RATE_W-1:0] rate_sel;
  logic [7:0]        rd_mux, rdata_q;

  rtc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .idx       (idx),
    .data_wr   (data_wr),
    .ctla      (ctla),
    .ctlb      (ctlb)
  );

  rtc_timekeep #(.UIP_CYCLES(UIP_CYCLES)) u_time (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sec_tick (sec_tick),
    .halt     (ctlb[7]),
    .wr_en    (data_wr),
    .wr_idx   (idx),
    .wr_data  (bus_wdata),
    .sec      (sec),
    .min      (min),
    .hr       (hr),
    .alm_sec  (alm_sec),
    .alm_min  (alm_min),
    .alm_hr   (alm_hr),
    .uip      (uip),
    .upd_evt  (upd_evt),
    .alm_evt  (alm_evt)
  );

  assign rate_sel = ctla[RATE_W-1:0];
  assign per_evt  = (rate_sel != '0) && rate_pulse[rate_sel];
  assign rd_en    = bus_rd && bus_sel;
  assign rd_clr   = rd_en && (idx == IDX_FLAGS);

  rtc_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .evt    ({per_evt, alm_evt, upd_evt}),
    .en     (ctlb[6:4]),
    .rd_clr (rd_clr),
    .flags  (flags),
    .irqf   (irqf)
  );

  always_comb begin
    case (idx)
      IDX_SEC:     rd_mux = sec;
      IDX_MIN:     rd_mux = min;
      IDX_HR:      rd_mux = hr;
      IDX_ALM_SEC: rd_mux = alm_sec;
      IDX_ALM_MIN: rd_mux = alm_min;
      IDX_ALM_HR:  rd_mux = alm_hr;
      IDX_CTLA:    rd_mux = {uip, ctla};
      IDX_CTLB:    rd_mux = ctlb;
      IDX_FLAGS:   rd_mux = {irqf, flags, 4'h0};
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irqf;

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> (flags != 3'b000));

  assert_halt_no_window_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctlb[7] && $past(ctlb[7])) |-> !uip);

endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

  localparam int UIP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        sec_tick;
  logic [15:0] rate_pulse;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  rtc_irq_ctrl #(.UIP_CYCLES(UIP)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .sec_tick   (sec_tick),
    .rate_pulse (rate_pulse),
    .irq        (irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {4'h0, idx};
    @(negedge clk); bus_sel = 1'b1; bus_wdata = val;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {4'h0, idx};
    @(negedge clk); bus_wr = 1'b0; bus_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UIP + 3) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); rate_pulse[n] = 1'b1;
    @(negedge clk); rate_pulse = '0;
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(4'd2, bcd(h)); wr(4'd1, bcd(m)); wr(4'd0, bcd(s));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int ones;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    sec_tick = 0; rate_pulse = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 irq", {7'h0, irq}, 8'h00);
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), v);
      check("R11 reg reset", v, 8'h00);
    end

    // R1 write and read back
    wr(4'd3, 8'h45); rd(4'd3, v); check("R1 alarm sec", v, 8'h45);
    wr(4'd1, 8'h17); rd(4'd1, v); check("R1 minutes", v, 8'h17);

    // R12 control A
    wr(4'd6, 8'hFF); rd(4'd6, v); check("R12 ctla", v, 8'h7F);
    wr(4'd6, 8'h00);

    // R2 exact window length and advance
    set_time(10, 20, 9);
    rd(4'd6, v);
    @(negedge clk); sec_tick = 1'b1; bus_sel = 1'b1; bus_rd = 1'b1;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sec_tick = 1'b0;
      ones += int'(bus_rdata[7]);
    end
    bus_rd = 1'b0;
    check("R2 window length", 8'(ones), 8'(UIP));
    rd(4'd0, v); check("R2 sec advance", v, 8'h10);

    // R2 tick during window ignored
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UIP + 3) @(negedge clk);
    rd(4'd0, v); check("R2 ignored tick", v, 8'h11);

    // R3 full wrap
    set_time(23, 59, 59); tick();
    rd(4'd0, v); check("R3 sec wrap", v, 8'h00);
    rd(4'd1, v); check("R3 min wrap", v, 8'h00);
    rd(4'd2, v); check("R3 hr wrap", v, 8'h00);

    // R4 halt
    wr(4'd7, 8'h90); rd(4'd7, v); check("R4 bit4 forced", v, 8'h80);
    wr(4'd7, 8'hD1); rd(4'd7, v); check("R4 bit4 forced again", v, 8'hC1);
    set_time(5, 6, 7); tick(); tick();
    rd(4'd0, v); check("R4 halted sec", v, 8'h07);
    rd(4'd6, v); check("R4 no window", v, 8'h00);

    // R5 full write with halt clear
    wr(4'd7, 8'h13); rd(4'd7, v); check("R5 ctlb dst", v, 8'h13);
    wr(4'd7, 8'h00);

    // R8 / R9 / R10 update-ended flag
    rd(4'd8, v);
    tick();
    check("R9 irq masked", {7'h0, irq}, 8'h00);
    wr(4'd7, 8'h10);
    check("R9 irq enabled", {7'h0, irq}, 8'h01);
    rd(4'd8, v); check("R8 uf flag", v, 8'h90);
    check("R10 irq cleared", {7'h0, irq}, 8'h00);
    rd(4'd8, v); check("R10 flags clear", v, 8'h00);

    // R6 alarm
    wr(4'd7, 8'h20);
    set_time(12, 34, 56);
    wr(4'd3, 8'h57); wr(4'd4, 8'h34); wr(4'd5, 8'h12);
    rd(4'd8, v); tick();
    check("R6 irq", {7'h0, irq}, 8'h01);
    rd(4'd8, v); check("R6 alarm flag", v, 8'hB0);
    tick(); rd(4'd8, v); check("R6 no match", v, 8'h10);

    // R7 periodic
    wr(4'd7, 8'h00); wr(4'd6, 8'h03);
    pulse(3); rd(4'd8, v); check("R7 periodic latch", v, 8'h40);
    pulse(5); rd(4'd8, v); check("R7 other rate", v, 8'h00);
    wr(4'd7, 8'h40); pulse(3);
    check("R9 periodic irq", {7'h0, irq}, 8'h01);
    rd(4'd8, v); check("R7 periodic enabled", v, 8'hC0);
    wr(4'd6, 8'h00); rate_pulse = '1;
    repeat (3) @(negedge clk);
    rate_pulse = '0;
    rd(4'd8, v); check("R7 disabled", v, 8'h00);

    // R10 event in same cycle as flag read
    wr(4'd7, 8'h00); wr(4'd6, 8'h03);
    rd(4'd8, v);
    @(negedge clk); bus_rd = 1'b1; rate_pulse[3] = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rate_pulse = '0;
    check("R10 read old", bus_rdata, 8'h00);
    rd(4'd8, v); check("R10 event kept", v, 8'h40);
    wr(4'd6, 8'h00);

    // random times with optional alarm match
    wr(4'd7, 8'h20);
    for (int it = 0; it < 24; it++) begin
      int s, m, h, ns, nm, nh;
      bit hit;
      s = int'($urandom_range(59)); m = int'($urandom_range(59)); h = int'($urandom_range(23));
      if (it < 3) begin s = 59; m = (it == 0) ? 59 : m; end
      ns = (s + 1) % 60;
      nm = (s == 59) ? (m + 1) % 60 : m;
      nh = (s == 59 && m == 59) ? (h + 1) % 24 : h;
      hit = $urandom_range(1) == 1;
      set_time(h, m, s);
      wr(4'd3, bcd(ns)); wr(4'd4, bcd(nm)); wr(4'd5, hit ? bcd(nh) : bcd((nh + 1) % 24));
      rd(4'd8, v);
      tick();
      rd(4'd0, v); check("R2 random sec", v, bcd(ns));
      rd(4'd1, v); check("R3 random min", v, bcd(nm));
      rd(4'd2, v); check("R3 random hr", v, bcd(nh));
      rd(4'd8, v); check("R6 random alarm", v, hit ? 8'hB0 : 8'h10);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule